// File: doc/BRIEF.md
# DMX Universe Refill Sequencer

This block keeps a DMX transmitter supplied with channel levels for one universe, fetching every level from an upstream controller at the moment the transmitter asks for it. It holds no frame storage of its own. At the start of a frame it sends a read command with start address zero to the upstream link and then turns the transmitter on. After that, each "next slot wanted" pulse from the transmitter triggers one byte read upstream, followed by one write of that byte into the transmitter.

Once the byte for the last channel has been written, the sequencer waits a fixed number of clock cycles between packets and then opens the next frame with a fresh command. Both sides are single-beat bus masters with a strobe and an acknowledge. A request holds its address, data and direction until its acknowledge arrives, and the sequencer stalls until then. The reset is synchronous and active high.

Top module: `dmx_refill_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, up_cyc, up_stb, tx_cyc, tx_stb and tx_enable are all 0.
- R2: Every frame opens with one upstream write beat (up_we = 1) where up_adr = 0 and up_dat_o equals the CMD_READ parameter.
- R3: tx_enable rises in the cycle after the first frame command is acknowledged, and it is 0 while that command is in flight.
- R4: No upstream read beat starts until the sequencer has seen a tx_ready pulse while waiting for one. Each pulse allows exactly one read.
- R5: Each upstream read is followed by exactly one transmitter write beat (tx_we = 1). That beat's tx_dat equals the byte acknowledged on up_dat_i, and its tx_adr equals the channel index.
- R6: Once a beat starts on either bus, its cyc and stb stay high and its address, data and direction stay unchanged until the cycle in which ack is sampled. The beat ends in the cycle after that.
- R7: Within a frame, up_adr on the reads and tx_adr on the writes run through 0, 1, ... CHAN_COUNT-1 in order. After the last channel's write, the block makes no read, and any tx_ready pulse during the gap has no effect.
- R8: The next frame command starts exactly GAP_CYCLES+1 clock cycles after the edge at which the last channel's write acknowledge is sampled.
- R9: Every new frame restarts at channel index 0.
- R10: The two buses never carry a beat in the same cycle.
- R11: Once set, tx_enable stays high across frames until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_cyc | output | 1 | Upstream beat in progress |
| up_stb | output | 1 | Upstream strobe |
| up_we | output | 1 | Upstream direction: 1 for the frame command, 0 for a byte read |
| up_adr | output | ADDR_W | Upstream address: 0 on the command, the channel index on reads |
| up_dat_o | output | 8 | Command opcode on the command beat |
| up_dat_i | input | 8 | Channel byte returned with up_ack |
| up_ack | input | 1 | Upstream acknowledge |
| tx_enable | output | 1 | Transmitter on |
| tx_ready | input | 1 | Transmitter pulse asking for the next channel byte |
| tx_cyc | output | 1 | Transmitter beat in progress |
| tx_stb | output | 1 | Transmitter strobe |
| tx_we | output | 1 | Transmitter direction, 1 on every beat |
| tx_adr | output | CNT_W | Channel index of the byte being written |
| tx_dat | output | 8 | Channel byte |
| tx_ack | input | 1 | Transmitter acknowledge |

## Verification
The bench builds the block with CHAN_COUNT = 12 and GAP_CYCLES = 6. A 12-channel frame is not a power of two, so it exercises the compare branch of the last-channel detector. It also keeps each frame short enough to run three complete frames and two frame-to-frame turnarounds. The short gap leaves room for a stray tx_ready pulse inside it while still making an off-by-one in the delay visible. The bench's slaves add zero to two wait states per beat, which exercises the stall-until-ack behaviour on both buses.

// File: rtl/dmx_refill_pkg.sv
package dmx_refill_pkg;

   typedef enum logic [1:0] {
      ST_INIT    = 2'd0,
      ST_DMXWAIT = 2'd1,
      ST_SPIREAD = 2'd2,
      ST_IPDWAIT = 2'd3
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_UP_REQ  = 2'd0,
      PH_UP_WAIT = 2'd1,
      PH_TX_REQ  = 2'd2,
      PH_TX_WAIT = 2'd3
   } seq_phase_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/dmx_wb_beat.sv
module dmx_wb_beat #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter bit          CLEAR_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_adr,
   input  logic [DATA_W-1:0] req_dat,
   output logic              cyc_o,
   output logic              stb_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] adr_o,
   output logic [DATA_W-1:0] dat_o,
   input  logic              ack_i,
   output logic              done_o
);

   logic finish;
   assign finish = cyc_o & ack_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_o <= 1'b0;
      end else if (!cyc_o && start) begin
         cyc_o <= 1'b1;
      end else if (finish) begin
         cyc_o <= 1'b0;
      end
   end

   generate
      if (CLEAR_IDLE) begin : g_clear
         always_ff @(posedge clk) begin
            if (rst || finish) begin
               we_o  <= 1'b0;
               adr_o <= '0;
               dat_o <= '0;
            end else if (!cyc_o && start) begin
               we_o  <= req_we;
               adr_o <= req_adr;
               dat_o <= req_dat;
            end
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (rst) begin
               we_o  <= 1'b0;
               adr_o <= '0;
               dat_o <= '0;
            end else if (!cyc_o && start) begin
               we_o  <= req_we;
               adr_o <= req_adr;
               dat_o <= req_dat;
            end
         end
      end
   endgenerate

   assign stb_o  = cyc_o;
   assign done_o = finish;

endmodule

// File: rtl/dmx_chan_counter.sv
module dmx_chan_counter #(
   parameter int unsigned CHAN_COUNT = 512,
   localparam int unsigned CNT_W     = $clog2(CHAN_COUNT),
   localparam int unsigned LAST      = CHAN_COUNT - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_last
);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         count <= '0;
      end else if (inc) begin
         count <= count + 1'b1;
      end
   end

   generate
      if ((CHAN_COUNT & (CHAN_COUNT - 1)) == 0) begin : g_pow2
         assign at_last = &count;
      end else begin : g_cmp
         assign at_last = (count == CNT_W'(LAST));
      end
   endgenerate

endmodule

// File: rtl/dmx_gap_timer.sv
module dmx_gap_timer #(
   parameter int unsigned GAP_CYCLES = 1000,
   localparam int unsigned GAP_W     = $clog2(GAP_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic tick,
   output logic last
);

   generate
      if (GAP_CYCLES == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [GAP_W-1:0] remain;
         always_ff @(posedge clk) begin
            if (rst) begin
               remain <= '0;
            end else if (load) begin
               remain <= GAP_W'(GAP_CYCLES);
            end else if (tick && remain != '0) begin
               remain <= remain - 1'b1;
            end
         end
         assign last = (remain == GAP_W'(1));
      end
   endgenerate

endmodule

// File: rtl/dmx_refill_ctrl.sv
module dmx_refill_ctrl
   import dmx_refill_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned CHAN_COUNT = 512,
   parameter int unsigned GAP_CYCLES = 1000,
   parameter logic [7:0]  CMD_READ   = 8'h03,
   localparam int unsigned CNT_W     = $clog2(CHAN_COUNT)
) (
   input  logic              clk,
   input  logic              rst,
   output logic              up_cyc,
   output logic              up_stb,
   output logic              up_we,
   output logic [ADDR_W-1:0] up_adr,
   output logic [7:0]        up_dat_o,
   input  logic [7:0]        up_dat_i,
   input  logic              up_ack,
   output logic              tx_enable,
   input  logic              tx_ready,
   output logic              tx_cyc,
   output logic              tx_stb,
   output logic              tx_we,
   output logic [CNT_W-1:0]  tx_adr,
   output logic [7:0]        tx_dat,
   input  logic              tx_ack
);

   generate
      if (CHAN_COUNT < 2) begin : g_bad_chan
         $error("CHAN_COUNT must be at least 2");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("GAP_CYCLES must be at least 1");
      end
      if (ADDR_W < CNT_W) begin : g_bad_addr
         $error("ADDR_W must hold a channel index");
      end
   endgenerate

   seq_state_t        state;
   seq_phase_t        phase;
   logic [BYTE_W-1:0] held_byte;
   logic [CNT_W-1:0]  chan;
   logic              chan_last;
   logic              gap_last;
   logic              up_start, up_done, up_req_we;
   logic [ADDR_W-1:0] up_req_adr;
   logic              tx_start, tx_done;
   logic              cnt_clear, cnt_inc, gap_load, gap_tick;

   always_comb begin
      up_start   = (state == ST_INIT || state == ST_SPIREAD) && phase == PH_UP_REQ;
      up_req_we  = (state == ST_INIT);
      up_req_adr = (state == ST_INIT) ? '0 : ADDR_W'(chan);
      tx_start   = (state == ST_SPIREAD) && phase == PH_TX_REQ;
      cnt_clear  = (state == ST_INIT);
      cnt_inc    = (state == ST_SPIREAD) && phase == PH_TX_WAIT && tx_done;
      gap_load   = cnt_inc && chan_last;
      gap_tick   = (state == ST_IPDWAIT);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_INIT;
         phase     <= PH_UP_REQ;
         tx_enable <= 1'b0;
         held_byte <= '0;
      end else begin
         unique case (state)
            ST_INIT: begin
               if (phase == PH_UP_REQ) begin
                  phase <= PH_UP_WAIT;
               end else if (up_done) begin
                  tx_enable <= 1'b1;
                  state     <= ST_DMXWAIT;
                  phase     <= PH_UP_REQ;
               end
            end
            ST_DMXWAIT: begin
               if (tx_ready) begin
                  state <= ST_SPIREAD;
                  phase <= PH_UP_REQ;
               end
            end
            ST_SPIREAD: begin
               unique case (phase)
                  PH_UP_REQ:  phase <= PH_UP_WAIT;
                  PH_UP_WAIT: if (up_done) begin
                                 held_byte <= up_dat_i;
                                 phase     <= PH_TX_REQ;
                              end
                  PH_TX_REQ:  phase <= PH_TX_WAIT;
                  PH_TX_WAIT: if (tx_done) begin
                                 phase <= PH_UP_REQ;
                                 state <= chan_last ? ST_IPDWAIT : ST_DMXWAIT;
                              end
               endcase
            end
            ST_IPDWAIT: begin
               if (gap_last) begin
                  state <= ST_INIT;
                  phase <= PH_UP_REQ;
               end
            end
         endcase
      end
   end

   dmx_wb_beat #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W), .CLEAR_IDLE(1'b0)) i_up_beat (
      .clk(clk), .rst(rst), .start(up_start), .req_we(up_req_we),
      .req_adr(up_req_adr), .req_dat(CMD_READ),
      .cyc_o(up_cyc), .stb_o(up_stb), .we_o(up_we), .adr_o(up_adr),
      .dat_o(up_dat_o), .ack_i(up_ack), .done_o(up_done)
   );

   dmx_wb_beat #(.ADDR_W(CNT_W), .DATA_W(BYTE_W), .CLEAR_IDLE(1'b1)) i_tx_beat (
      .clk(clk), .rst(rst), .start(tx_start), .req_we(1'b1),
      .req_adr(chan), .req_dat(held_byte),
      .cyc_o(tx_cyc), .stb_o(tx_stb), .we_o(tx_we), .adr_o(tx_adr),
      .dat_o(tx_dat), .ack_i(tx_ack), .done_o(tx_done)
   );

   dmx_chan_counter #(.CHAN_COUNT(CHAN_COUNT)) i_chan (
      .clk(clk), .rst(rst), .clear(cnt_clear), .inc(cnt_inc),
      .count(chan), .at_last(chan_last)
   );

   dmx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap (
      .clk(clk), .rst(rst), .load(gap_load), .tick(gap_tick), .last(gap_last)
   );

endmodule

// File: rtl/dmx_refill_checker.sv
module dmx_refill_checker #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              up_cyc,
   input logic              up_stb,
   input logic              up_we,
   input logic [ADDR_W-1:0] up_adr,
   input logic [7:0]        up_dat_o,
   input logic              up_ack,
   input logic              tx_enable,
   input logic              tx_cyc,
   input logic              tx_stb,
   input logic              tx_we,
   input logic [CNT_W-1:0]  tx_adr,
   input logic [7:0]        tx_dat,
   input logic              tx_ack
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!up_cyc && !up_stb && !tx_cyc && !tx_stb && !tx_enable));

   assert_enable_after_cmd_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_enable) |-> $past(up_cyc && up_ack && up_we));

   assert_write_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_cyc) |-> tx_enable);

   assert_up_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (up_cyc && !up_ack) |=> (up_cyc && up_stb && $stable(up_adr)
                               && $stable(up_we) && $stable(up_dat_o)));

   assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (tx_cyc && !tx_ack) |=> (tx_cyc && tx_stb && $stable(tx_adr)
                               && $stable(tx_we) && $stable(tx_dat)));

   assert_up_single_beat_R6: assert property (@(posedge clk) disable iff (rst)
      (up_cyc && up_ack) |=> !up_cyc);

   assert_tx_single_beat_R6: assert property (@(posedge clk) disable iff (rst)
      (tx_cyc && tx_ack) |=> !tx_cyc);

   assert_one_bus_R10: assert property (@(posedge clk) disable iff (rst)
      !(up_cyc && tx_cyc));

   assert_enable_sticky_R11: assert property (@(posedge clk) disable iff (rst)
      tx_enable |=> tx_enable);

endmodule

bind dmx_refill_ctrl dmx_refill_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_refill_chk (
   .clk(clk), .rst(rst), .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we),
   .up_adr(up_adr), .up_dat_o(up_dat_o), .up_ack(up_ack), .tx_enable(tx_enable),
   .tx_cyc(tx_cyc), .tx_stb(tx_stb), .tx_we(tx_we), .tx_adr(tx_adr),
   .tx_dat(tx_dat), .tx_ack(tx_ack)
);

// File: tb/test_dmx_refill_ctrl.sv
module test_dmx_refill_ctrl;

   localparam int ADDR_W = 16;
   localparam int CHAN   = 12;
   localparam int GAP    = 6;
   localparam int FRAMES = 3;
   localparam int CW     = $clog2(CHAN);
   localparam logic [7:0] CMD = 8'hA5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic              up_cyc, up_stb, up_we;
   logic [ADDR_W-1:0] up_adr;
   logic [7:0]        up_dat_o;
   logic [7:0]        up_dat_i = 8'h00;
   logic              up_ack = 1'b0;
   logic              tx_enable;
   logic              tx_ready = 1'b0;
   logic              tx_cyc, tx_stb, tx_we;
   logic [CW-1:0]     tx_adr;
   logic [7:0]        tx_dat;
   logic              tx_ack = 1'b0;

   dmx_refill_ctrl #(.ADDR_W(ADDR_W), .CHAN_COUNT(CHAN), .GAP_CYCLES(GAP), .CMD_READ(CMD))
   i_dmx_refill_ctrl (
      .clk(clk), .rst(rst), .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we),
      .up_adr(up_adr), .up_dat_o(up_dat_o), .up_dat_i(up_dat_i), .up_ack(up_ack),
      .tx_enable(tx_enable), .tx_ready(tx_ready), .tx_cyc(tx_cyc), .tx_stb(tx_stb),
      .tx_we(tx_we), .tx_adr(tx_adr), .tx_dat(tx_dat), .tx_ack(tx_ack)
   );

   int n_checks = 0;
   int n_fails  = 0;
   int edge_n   = 0;
   always @(posedge clk) edge_n <= edge_n + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] level_of(input int ch, input int fr);
      return 8'(ch * 7 + fr * 29 + 3);
   endfunction

   typedef struct {
      int         ch;
      logic [7:0] b;
   } slot_t;
   slot_t sb[$];

   int cmd_cnt   = 0;
   int tx_done   = 0;
   int credit    = 0;
   int next_ch   = 0;
   int frame     = 0;
   int last_edge = 0;
   bit all_done  = 1'b0;
   bit finished  = 1'b0;

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   // upstream slave: answers commands and byte reads, feeds the scoreboard
   initial begin
      int  wait_n = 0;
      int  seed   = 0;
      bit  prev   = 1'b0;
      forever begin
         @(negedge clk);
         if (up_ack) begin
            up_ack = 1'b0;
         end else if (up_cyc && !rst) begin
            if (!prev && up_we && cmd_cnt > 0)
               check(edge_n - last_edge == GAP + 1, "R8", "gap cycles",
                     edge_n - last_edge, GAP + 1);
            check(up_stb == 1'b1, "R6", "up_stb with up_cyc", int'(up_stb), 1);
            if (wait_n > 0) begin
               wait_n--;
            end else begin
               if (up_we) begin
                  check(up_adr == '0, "R2", "command address", int'(up_adr), 0);
                  check(up_dat_o == CMD, "R2", "command opcode", int'(up_dat_o), int'(CMD));
                  if (cmd_cnt == 0)
                     check(tx_enable == 1'b0, "R3", "enable before first command ack",
                           int'(tx_enable), 0);
                  else
                     check(tx_enable == 1'b1, "R11", "enable held across frames",
                           int'(tx_enable), 1);
                  cmd_cnt++;
               end else begin
                  check(credit > 0, "R4", "read without ready", credit, 1);
                  if (credit > 0) credit--;
                  if (next_ch == 0 && frame > 0)
                     check(int'(up_adr) == 0, "R9", "first read of new frame", int'(up_adr), 0);
                  else
                     check(int'(up_adr) == next_ch, "R7", "read channel order",
                           int'(up_adr), next_ch);
                  up_dat_i = level_of(next_ch, frame);
                  sb.push_back('{next_ch, up_dat_i});
                  next_ch++;
               end
               up_ack = 1'b1;
               seed++;
               wait_n = seed % 3;
            end
         end
         prev = up_cyc;
      end
   end

   // transmitter slave: monitor popping the scoreboard
   initial begin
      int wait_n = 0;
      int seed   = 1;
      forever begin
         @(negedge clk);
         if (tx_ack) begin
            tx_ack = 1'b0;
         end else if (tx_cyc && !rst) begin
            if (wait_n > 0) begin
               wait_n--;
            end else begin
               if (sb.size() == 0) begin
                  check(1'b0, "R5", "write with no pending read", 1, 0);
               end else begin
                  slot_t it;
                  it = sb.pop_front();
                  check(tx_dat == it.b, "R5", "forwarded byte", int'(tx_dat), int'(it.b));
                  check(int'(tx_adr) == it.ch, "R5", "write channel index", int'(tx_adr), it.ch);
                  check(tx_we == 1'b1, "R5", "write direction", int'(tx_we), 1);
                  if (it.ch == CHAN - 1) begin
                     last_edge = edge_n + 1;
                     next_ch   = 0;
                     frame++;
                  end
               end
               tx_ack = 1'b1;
               tx_done++;
               seed++;
               wait_n = seed % 3;
            end
         end
      end
   end

   // ready driver
   initial begin
      wait (!rst);
      for (int f = 0; f < FRAMES; f++) begin
         wait (cmd_cnt == f + 1);
         for (int ch = 0; ch < CHAN; ch++) begin
            for (int d = 0; d < 1 + (ch + f) % 3; d++) begin
               @(negedge clk);
               check(!up_cyc && !tx_cyc, "R4", "bus idle before ready",
                     int'(up_cyc) + int'(tx_cyc), 0);
            end
            if (ch == 0)
               check(tx_enable == 1'b1, "R3", "enable after command", int'(tx_enable), 1);
            tx_ready = 1'b1;
            credit++;
            @(negedge clk);
            tx_ready = 1'b0;
            wait (tx_done == f * CHAN + ch + 1);
         end
         // stray ready inside the gap must start nothing
         @(negedge clk);
         @(negedge clk);
         tx_ready = 1'b1;
         @(negedge clk);
         tx_ready = 1'b0;
         check(!up_cyc && !tx_cyc, "R7", "no beat after stray ready in gap",
               int'(up_cyc) + int'(tx_cyc), 0);
      end
      wait (cmd_cnt == FRAMES + 1);
      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
      check(frame == FRAMES, "R9", "frames completed", frame, FRAMES);
      all_done = 1'b1;
   end

   // reset and end of run
   initial begin
      rst = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(!up_cyc && !up_stb && !tx_cyc && !tx_stb, "R1", "bus idle in reset",
               int'(up_cyc) + int'(tx_cyc), 0);
         check(tx_enable == 1'b0, "R1", "enable low in reset", int'(tx_enable), 0);
      end
      rst = 1'b0;
      @(negedge clk);
      check(tx_enable == 1'b0, "R1", "enable low after reset", int'(tx_enable), 0);
      wait (all_done);
      summary();
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog: actual %0d frames expected %0d", frame, FRAMES);
      summary();
   end

endmodule